// File: doc/BRIEF.md
# Pass-Through DMA Stream Engine

This block moves 32-bit words for one DMA stream. Every word is first fetched from the source side into a small internal queue, then written from that queue to the destination side. Software programs a memory-side address, a peripheral-side address, a word count and a control word, then sets the enable bit. The engine drives two request/ready master ports, one for memory and one for the peripheral. It reacts to a level-sensitive peripheral request line and raises a sticky completion interrupt.

There are three directions. In peripheral-to-memory the source is the peripheral port, and each request moves one word. In memory-to-peripheral the queue is filled from memory as soon as the stream starts, and each request delivers one queued word. In memory-to-memory the source is read through the peripheral port at the peripheral-side address, and the engine runs without waiting for any request. Circular mode restarts a finished sequence by itself. Normal mode stops and waits for software.

Top module: `dma_stream_engine`

## Requirements
- R1: After reset the stream is disabled, the remaining count, both address registers and the interrupt are zero, and neither port requests.
- R2: Writes use `cfg_sel`: 0 = memory address, 1 = peripheral address, 2 = count (low 16 bits), 3 = control. The control bits are: bit 0 enable, bits 2:1 direction (0 peripheral-to-memory, 1 memory-to-peripheral, 2 memory-to-memory), bit 3 memory increment, bit 4 peripheral increment, bit 5 circular, bit 8 write-one-to-clear completion. In peripheral-to-memory, while `per_dreq` is high, each word is read at the peripheral address and then written to memory at the memory address.
- R3: In memory-to-peripheral, memory reads start on enable with no request. They continue while the queue (4 entries) has room and holds fewer words than remain. Each cycle in which `per_dreq` is high with a queued word causes one peripheral write, and the queue is then refilled.
- R4: In memory-to-memory, words are read through the peripheral port at the peripheral address and written to memory, whatever the level of `per_dreq`.
- R5: After each access on its side, an address register advances by 4 if its increment bit is set. Otherwise it stays the same.
- R6: The remaining count drops by one after each destination write. When it reaches zero in normal mode, the stream disables itself with count 0 and `irq` goes high.
- R7: In circular mode, the last write of a sequence sets `irq` and reloads the count and both addresses to their programmed values. The stream stays enabled.
- R8: An enable is refused, and the stream stays disabled, if the direction is memory-to-memory with circular set, if the direction code is 3, or if the count is zero.
- R9: While the stream is enabled, or an access is still pending, writes to the address and count registers are ignored. A control write then changes only the enable and clear bits.
- R10: Clearing enable lets an access that has already started finish its word, destination write included. It then stops with the count preserved, and queued prefetched words are dropped.
- R11: Writing control with bit 8 set clears `irq`. Writing it with bit 8 clear leaves `irq` as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| per_dreq | input | 1 | Peripheral transfer request (level) |
| mem_req | output | 1 | Memory port request |
| mem_we | output | 1 | Memory port write (1) / read (0) |
| mem_addr | output | 32 | Memory port byte address |
| mem_wdata | output | 32 | Memory port write data |
| mem_ready | input | 1 | Memory port access completes this cycle |
| mem_rdata | input | 32 | Memory port read data |
| per_req | output | 1 | Peripheral port request |
| per_we | output | 1 | Peripheral port write (1) / read (0) |
| per_addr | output | 32 | Peripheral port byte address |
| per_wdata | output | 32 | Peripheral port write data |
| per_ready | input | 1 | Peripheral port access completes this cycle |
| per_rdata | input | 32 | Peripheral port read data |
| stream_en | output | 1 | Stream enabled |
| remaining | output | 16 | Words left in the sequence |
| cur_maddr | output | 32 | Current memory-side address |
| cur_paddr | output | 32 | Current peripheral-side address |
| irq | output | 1 | Sticky completion interrupt |

## Verification
The assertions assume that both port slaves answer every request with `ready` in some later or the same cycle, and that read data is valid in the cycle `ready` is high. They also assume software does not try to redirect a stream while an access is still pending. The bench models both slaves as zero-wait responders, except when it deliberately stalls the peripheral port to freeze a load in flight. It holds `per_dreq` as a level and drops it only at falling edges, so the engine never sees a request that vanishes mid-cycle. Every register write is made while the engine is idle or is meant to be ignored.

// File: rtl/dse_pkg.sv
package dse_pkg;
    typedef enum logic [1:0] {
        DIR_P2M = 2'd0,
        DIR_M2P = 2'd1,
        DIR_M2M = 2'd2,
        DIR_BAD = 2'd3
    } dir_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_STORE = 2'd2
    } state_e;

    localparam logic [1:0] SEL_MADDR = 2'd0;
    localparam logic [1:0] SEL_PADDR = 2'd1;
    localparam logic [1:0] SEL_COUNT = 2'd2;
    localparam logic [1:0] SEL_CTRL  = 2'd3;

    localparam int unsigned CB_EN   = 0;
    localparam int unsigned CB_DIR  = 1;
    localparam int unsigned CB_MINC = 3;
    localparam int unsigned CB_PINC = 4;
    localparam int unsigned CB_CIRC = 5;
    localparam int unsigned CB_CLR  = 8;
endpackage

// File: rtl/dse_fifo.sv
module dse_fifo #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 4,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic              empty
);
    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] slot;
        logic [PTR_W-1:0]             wp;
        logic [PTR_W-1:0]             rp;
        logic [CNT_W-1:0]             cnt;
    } fifo_t;

    fifo_t q_q, q_d;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) return '0;
        return p + 1'b1;
    endfunction

    always_comb begin
        q_d = q_q;
        if (flush) begin
            q_d.wp  = '0;
            q_d.rp  = '0;
            q_d.cnt = '0;
        end else begin
            if (push) begin
                q_d.slot[q_q.wp] = push_data;
                q_d.wp           = bump(q_q.wp);
            end
            if (pop) q_d.rp = bump(q_q.rp);
            case ({push, pop})
                2'b10:   q_d.cnt = q_q.cnt + 1'b1;
                2'b01:   q_d.cnt = q_q.cnt - 1'b1;
                default: q_d.cnt = q_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign head  = q_q.slot[q_q.rp];
    assign count = q_q.cnt;
    assign full  = (q_q.cnt == CNT_W'(DEPTH));
    assign empty = (q_q.cnt == '0);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && full && !pop));
    assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop && empty));
endmodule

// File: rtl/dse_regs.sv
module dse_regs
    import dse_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned STEP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              busy,
    input  logic              src_done,
    input  logic              dst_done,
    output logic              en,
    output dir_e              dir,
    output logic [ADDR_W-1:0] maddr,
    output logic [ADDR_W-1:0] paddr,
    output logic [CNT_W-1:0]  count,
    output logic              done
);
    typedef struct packed {
        logic              en;
        dir_e              dir;
        logic              minc;
        logic              pinc;
        logic              circ;
        logic              done;
        logic [ADDR_W-1:0] maddr;
        logic [ADDR_W-1:0] paddr;
        logic [CNT_W-1:0]  count;
        logic [ADDR_W-1:0] maddr0;
        logic [ADDR_W-1:0] paddr0;
        logic [CNT_W-1:0]  count0;
    } regs_t;

    regs_t r_q, r_d;
    logic  locked, is_m2p, mem_step, per_step;
    dir_e  new_dir;

    assign locked   = r_q.en || busy;
    assign is_m2p   = (r_q.dir == DIR_M2P);
    assign mem_step = is_m2p ? src_done : dst_done;
    assign per_step = is_m2p ? dst_done : src_done;
    assign new_dir  = dir_e'(wr_data[CB_DIR+1:CB_DIR]);

    always_comb begin
        r_d = r_q;
        if (wr_en && !locked) begin
            unique case (wr_sel)
                SEL_MADDR: begin r_d.maddr = wr_data; r_d.maddr0 = wr_data; end
                SEL_PADDR: begin r_d.paddr = wr_data; r_d.paddr0 = wr_data; end
                SEL_COUNT: begin
                    r_d.count  = wr_data[CNT_W-1:0];
                    r_d.count0 = wr_data[CNT_W-1:0];
                end
                default: begin
                    r_d.dir  = new_dir;
                    r_d.minc = wr_data[CB_MINC];
                    r_d.pinc = wr_data[CB_PINC];
                    r_d.circ = wr_data[CB_CIRC];
                    r_d.en   = wr_data[CB_EN] && (r_q.count != '0) && (new_dir != DIR_BAD)
                               && !(new_dir == DIR_M2M && wr_data[CB_CIRC]);
                end
            endcase
        end else if (wr_en && wr_sel == SEL_CTRL && r_q.en) begin
            r_d.en = wr_data[CB_EN];
        end
        if (wr_en && wr_sel == SEL_CTRL && wr_data[CB_CLR]) r_d.done = 1'b0;

        if (mem_step && r_q.minc) r_d.maddr = r_q.maddr + ADDR_W'(STEP);
        if (per_step && r_q.pinc) r_d.paddr = r_q.paddr + ADDR_W'(STEP);
        if (dst_done) begin
            if (r_q.count == CNT_W'(1)) begin
                r_d.done = 1'b1;
                if (r_q.circ) begin
                    r_d.count = r_q.count0;
                    r_d.maddr = r_q.maddr0;
                    r_d.paddr = r_q.paddr0;
                end else begin
                    r_d.count = '0;
                    r_d.en    = 1'b0;
                end
            end else begin
                r_d.count = r_q.count - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign en    = r_q.en;
    assign dir   = r_q.dir;
    assign maddr = r_q.maddr;
    assign paddr = r_q.paddr;
    assign count = r_q.count;
    assign done  = r_q.done;

    assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dst_done && r_q.count > CNT_W'(1) |=> r_q.count == $past(r_q.count) - CNT_W'(1));
    assert_no_m2m_circ_R8: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.en |-> !(r_q.dir == DIR_M2M && r_q.circ) && r_q.dir != DIR_BAD);
    assert_locked_regs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.en && wr_en && wr_sel != SEL_CTRL && !src_done && !dst_done
        |=> $stable(r_q.maddr) && $stable(r_q.paddr) && $stable(r_q.count));
endmodule

// File: rtl/dma_stream_engine.sv
module dma_stream_engine
    import dse_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned FIFO_DEPTH = 4,
    localparam int unsigned FC_W      = $clog2(FIFO_DEPTH + 1),
    localparam int unsigned STEP      = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              per_dreq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              per_req,
    output logic              per_we,
    output logic [ADDR_W-1:0] per_addr,
    output logic [DATA_W-1:0] per_wdata,
    input  logic              per_ready,
    input  logic [DATA_W-1:0] per_rdata,
    output logic              stream_en,
    output logic [CNT_W-1:0]  remaining,
    output logic [ADDR_W-1:0] cur_maddr,
    output logic [ADDR_W-1:0] cur_paddr,
    output logic              irq
);
    typedef struct packed {
        state_e st;
    } fsm_t;

    fsm_t fsm_q, fsm_d;

    logic              en, done, flush, load_done, store_done;
    dir_e              dir;
    logic [ADDR_W-1:0] maddr, paddr;
    logic [CNT_W-1:0]  count;
    logic [DATA_W-1:0] f_head;
    logic [FC_W-1:0]   f_cnt;
    logic              f_full, f_empty;
    logic              is_m2p, is_m2m, load_ok, src_ready, dst_ready;

    dse_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .STEP(STEP)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we), .wr_sel(cfg_sel), .wr_data(cfg_wdata),
        .busy(fsm_q.st != ST_IDLE),
        .src_done(load_done), .dst_done(store_done),
        .en(en), .dir(dir), .maddr(maddr), .paddr(paddr),
        .count(count), .done(done)
    );

    dse_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(load_done), .push_data(is_m2p ? mem_rdata : per_rdata),
        .pop(store_done), .head(f_head), .count(f_cnt),
        .full(f_full), .empty(f_empty)
    );

    assign is_m2p    = (dir == DIR_M2P);
    assign is_m2m    = (dir == DIR_M2M);
    assign src_ready = is_m2p ? mem_ready : per_ready;
    assign dst_ready = is_m2p ? per_ready : mem_ready;
    assign load_ok   = !f_full && (CNT_W'(f_cnt) < count)
                       && (is_m2p || (f_empty && (is_m2m || per_dreq)));

    always_comb begin
        fsm_d      = fsm_q;
        flush      = 1'b0;
        load_done  = 1'b0;
        store_done = 1'b0;
        unique case (fsm_q.st)
            ST_IDLE: begin
                if (!en)                                  flush = 1'b1;
                else if (is_m2p && per_dreq && !f_empty) fsm_d.st = ST_STORE;
                else if (load_ok)                         fsm_d.st = ST_LOAD;
            end
            ST_LOAD: begin
                load_done = src_ready;
                if (src_ready) fsm_d.st = is_m2p ? ST_IDLE : ST_STORE;
            end
            ST_STORE: begin
                store_done = dst_ready;
                if (dst_ready) fsm_d.st = ST_IDLE;
            end
            default: fsm_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '{st: ST_IDLE};
        else        fsm_q <= fsm_d;
    end

    assign mem_req   = (fsm_q.st == ST_LOAD && is_m2p) || (fsm_q.st == ST_STORE && !is_m2p);
    assign per_req   = (fsm_q.st == ST_LOAD && !is_m2p) || (fsm_q.st == ST_STORE && is_m2p);
    assign mem_we    = (fsm_q.st == ST_STORE);
    assign per_we    = (fsm_q.st == ST_STORE);
    assign mem_addr  = maddr;
    assign per_addr  = paddr;
    assign mem_wdata = f_head;
    assign per_wdata = f_head;

    assign stream_en = en;
    assign remaining = count;
    assign cur_maddr = maddr;
    assign cur_paddr = paddr;
    assign irq       = done;

    assert_mem_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we));
    assert_per_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        per_req && !per_ready |=> per_req && $stable(per_addr) && $stable(per_we));
endmodule

// File: tb/dma_stream_engine_bench.sv
module dma_stream_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic        per_dreq = 1'b0;
    logic        mem_req, mem_we, mem_ready, per_req, per_we, per_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, per_addr, per_wdata, per_rdata;
    logic        stream_en, irq;
    logic [15:0] remaining;
    logic [31:0] cur_maddr, cur_paddr;
    logic        per_stall = 1'b0;
    logic        fin = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] mem [0:63];
    logic [31:0] per_log [0:63];
    int mem_rd_n, mem_wr_n, per_wr_n;

    always #2 clk = ~clk;

    dma_stream_engine u_dma_stream_engine (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .per_dreq(per_dreq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .per_req(per_req), .per_we(per_we), .per_addr(per_addr), .per_wdata(per_wdata),
        .per_ready(per_ready), .per_rdata(per_rdata),
        .stream_en(stream_en), .remaining(remaining), .cur_maddr(cur_maddr),
        .cur_paddr(cur_paddr), .irq(irq)
    );

    function automatic logic [31:0] mem_init(input int idx);
        return 32'h5A00_0000 + 32'(idx);
    endfunction

    function automatic logic [31:0] per_val(input logic [31:0] a);
        return 32'hC000_0000 | a;
    endfunction

    assign mem_ready = 1'b1;
    assign per_ready = !per_stall;
    assign mem_rdata = mem[mem_addr[7:2]];
    assign per_rdata = per_val(per_addr);

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem[i] <= mem_init(i);
            mem_rd_n <= 0; mem_wr_n <= 0; per_wr_n <= 0;
        end else begin
            if (mem_req && mem_ready && mem_we) begin
                mem[mem_addr[7:2]] <= mem_wdata;
                mem_wr_n <= mem_wr_n + 1;
            end
            if (mem_req && mem_ready && !mem_we) mem_rd_n <= mem_rd_n + 1;
            if (per_req && per_ready && per_we) begin
                per_log[per_wr_n[5:0]] <= per_wdata;
                per_wr_n <= per_wr_n + 1;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [31:0] ctrl(input logic e, input logic [1:0] d, input logic mi,
                                         input logic pi, input logic ci, input logic cl);
        return {23'd0, cl, 2'd0, ci, pi, mi, d, e};
    endfunction

    task automatic wait_irq(input string tag);
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (irq) break;
        end
        chk({tag, " irq raised"}, {31'd0, irq}, 32'd1);
    endtask

    // dir[27:26] minc[25] pinc[24] count[23:16] maddr[15:8] paddr[7:0]
    localparam logic [27:0] VEC [0:5] = '{
        {2'd0, 1'b1, 1'b0, 8'd3, 8'h40, 8'h10},
        {2'd0, 1'b1, 1'b1, 8'd2, 8'h80, 8'h20},
        {2'd1, 1'b1, 1'b0, 8'd5, 8'h00, 8'h30},
        {2'd1, 1'b0, 1'b1, 8'd2, 8'h08, 8'h40},
        {2'd2, 1'b1, 1'b1, 8'd4, 8'hA0, 8'h00},
        {2'd2, 1'b1, 1'b0, 8'd1, 8'hC0, 8'h04}
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!fin) begin
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_fail + 1);
            $finish;
        end
    end

    initial begin
        logic [1:0]  d;
        logic        mi, pi;
        int          cnt, snap_p, snap_r, snap_w;
        logic [31:0] ma, pa, sa, da, exp_d;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 stream_en", {31'd0, stream_en}, 32'd0);
        chk("R1 remaining", {16'd0, remaining}, 32'd0);
        chk("R1 maddr", cur_maddr, 32'd0);
        chk("R1 paddr", cur_paddr, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 requests", {30'd0, mem_req, per_req}, 32'd0);

        // Table-driven transfers (R2, R4, R5, R6; R3 delivery)
        for (int v = 0; v < 6; v++) begin
            d = VEC[v][27:26]; mi = VEC[v][25]; pi = VEC[v][24];
            cnt = int'(VEC[v][23:16]);
            ma = {24'd0, VEC[v][15:8]}; pa = {24'd0, VEC[v][7:0]};
            wr(2'd3, ctrl(1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1));
            wr(2'd0, ma); wr(2'd1, pa); wr(2'd2, 32'(cnt));
            snap_p = per_wr_n;
            per_dreq = 1'b1;
            wr(2'd3, ctrl(1'b1, d, mi, pi, 1'b0, 1'b0));
            wait_irq($sformatf("R6 vec%0d", v));
            per_dreq = 1'b0;
            repeat (2) @(negedge clk);
            chk($sformatf("R6 vec%0d disabled", v), {31'd0, stream_en}, 32'd0);
            chk($sformatf("R6 vec%0d count", v), {16'd0, remaining}, 32'd0);
            chk($sformatf("R5 vec%0d maddr", v), cur_maddr, ma + (mi ? 32'(4 * cnt) : 32'd0));
            chk($sformatf("R5 vec%0d paddr", v), cur_paddr, pa + (pi ? 32'(4 * cnt) : 32'd0));
            for (int k = 0; k < cnt; k++) begin
                sa = (d == 2'd1) ? ma + (mi ? 32'(4 * k) : 32'd0) : pa + (pi ? 32'(4 * k) : 32'd0);
                if (d == 2'd1) begin
                    exp_d = mem_init(int'(sa[7:2]));
                    chk($sformatf("R3 vec%0d word%0d", v, k), per_log[6'(snap_p + k)], exp_d);
                end else begin
                    da = ma + 32'(4 * k);
                    chk($sformatf("%s vec%0d word%0d", (d == 2'd0) ? "R2" : "R4", v, k),
                        mem[da[7:2]], per_val(sa));
                end
            end
        end

        // R3 prefetch without request, then one delivery and refill
        wr(2'd3, ctrl(1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1));
        wr(2'd0, 32'h10); wr(2'd1, 32'h50); wr(2'd2, 32'd6);
        snap_r = mem_rd_n; snap_p = per_wr_n;
        wr(2'd3, ctrl(1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0));
        repeat (20) @(negedge clk);
        chk("R3 prefetch reads", 32'(mem_rd_n - snap_r), 32'd4);
        chk("R3 no delivery yet", 32'(per_wr_n - snap_p), 32'd0);
        chk("R3 count kept", {16'd0, remaining}, 32'd6);
        per_dreq = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (per_wr_n != snap_p) break;
        end
        per_dreq = 1'b0;
        repeat (6) @(negedge clk);
        chk("R3 one delivery", 32'(per_wr_n - snap_p), 32'd1);
        chk("R3 delivered data", per_log[6'(snap_p)], mem_init(4));
        chk("R3 refill", 32'(mem_rd_n - snap_r), 32'd5);
        chk("R6 count after one", {16'd0, remaining}, 32'd5);
        // R10 disable drops queued words
        wr(2'd3, ctrl(1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0));
        per_dreq = 1'b1;
        repeat (10) @(negedge clk);
        per_dreq = 1'b0;
        chk("R10 no delivery after disable", 32'(per_wr_n - snap_p), 32'd1);
        chk("R10 count preserved", {16'd0, remaining}, 32'd5);

        // R10 disable while a load is stalled: word still completes
        wr(2'd0, 32'hF0); wr(2'd1, 32'h70); wr(2'd2, 32'd4);
        snap_w = mem_wr_n;
        per_stall = 1'b1;
        per_dreq = 1'b1;
        wr(2'd3, ctrl(1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0));
        repeat (3) @(negedge clk);
        chk("R10 load pending", {31'd0, per_req}, 32'd1);
        wr(2'd3, ctrl(1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0));
        per_stall = 1'b0;
        repeat (10) @(negedge clk);
        per_dreq = 1'b0;
        chk("R10 boundary word written", mem[6'h3C], per_val(32'h70));
        chk("R10 single store", 32'(mem_wr_n - snap_w), 32'd1);
        chk("R10 count", {16'd0, remaining}, 32'd3);
        chk("R10 stopped", {29'd0, stream_en, mem_req, per_req}, 32'd0);

        // R7 circular, R11 clear
        wr(2'd3, ctrl(1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1));
        wr(2'd0, 32'hE0); wr(2'd1, 32'h60); wr(2'd2, 32'd2);
        snap_w = mem_wr_n;
        per_dreq = 1'b1;
        wr(2'd3, ctrl(1'b1, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0));
        wait_irq("R7 wrap1");
        per_dreq = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 still enabled", {31'd0, stream_en}, 32'd1);
        chk("R7 count reload", {16'd0, remaining}, 32'd2);
        chk("R7 maddr reload", cur_maddr, 32'hE0);
        chk("R7 paddr reload", cur_paddr, 32'h60);
        chk("R7 data0", mem[6'h38], per_val(32'h60));
        chk("R7 data1", mem[6'h39], per_val(32'h64));
        wr(2'd3, ctrl(1'b1, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0));
        chk("R11 no clear without bit8", {31'd0, irq}, 32'd1);
        wr(2'd3, ctrl(1'b1, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1));
        chk("R11 cleared", {31'd0, irq}, 32'd0);
        chk("R11 enable kept", {31'd0, stream_en}, 32'd1);
        // R9 locked registers while enabled
        wr(2'd0, 32'h99C); wr(2'd2, 32'd7);
        chk("R9 maddr ignored", cur_maddr, 32'hE0);
        chk("R9 count ignored", {16'd0, remaining}, 32'd2);
        per_dreq = 1'b1;
        wait_irq("R7 wrap2");
        per_dreq = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 second wrap count", {16'd0, remaining}, 32'd2);
        chk("R7 second wrap stores", 32'(mem_wr_n - snap_w), 32'd4);
        wr(2'd3, ctrl(1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1));

        // R8 refused enables
        wr(2'd0, 32'h40); wr(2'd1, 32'h00); wr(2'd2, 32'd3);
        wr(2'd3, ctrl(1'b1, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0));
        repeat (4) @(negedge clk);
        chk("R8 m2m circular refused", {30'd0, stream_en, mem_req | per_req}, 32'd0);
        wr(2'd3, ctrl(1'b1, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0));
        chk("R8 bad direction refused", {31'd0, stream_en}, 32'd0);
        wr(2'd2, 32'd0);
        wr(2'd3, ctrl(1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0));
        repeat (4) @(negedge clk);
        chk("R8 zero count refused", {30'd0, stream_en, mem_req | per_req}, 32'd0);

        fin = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule